// File: doc/BRIEF.md
# Calibration and Trigger Command Sequencer

This block owns the serial command line to a pixel readout chip. The line carries one bit per clock at 40 MHz. While idle, the block acts as a transparent relay. A host-side source offers command bits with a valid flag, and each accepted bit appears on the line one clock later, untouched.

On a start request the block takes the line for itself. It emits a locally stored calibration-pulse pattern, waits a programmable latency and emits a locally stored trigger pattern. After a programmable interval it repeats the pair, until the programmed number of pairs has gone out. Both patterns are parameters and are shifted out most significant bit first. Latency, interval and pair count are captured at the start, so changes made during a run have no effect on it. Host bits are refused while a run is in progress, so host traffic and generated commands never mix on the line. An abort ends the run cleanly at a command edge.

Top module: `cal_trig_seq`

## Requirements
- R1: After synchronous reset `cmd_out`, `busy` and `done` are 0 and `host_ready` is 1.
- R2: While idle, a bit offered with `host_valid` high is accepted and driven on `cmd_out` in the following clock. A clock without `host_valid` gives 0 on the following clock.
- R3: `host_ready` is 0 whenever `busy` is 1 or `start` is high. Host bits offered during a run never reach `cmd_out`, and the first idle clock after a run outputs 0.
- R4: A `start` sampled while idle with a nonzero `cfg_count` puts the first calibration bit (pattern MSB) on `cmd_out` in the next clock. The remaining bits follow MSB first, one per clock. A `start` sampled while busy has no effect.
- R5: After the last calibration bit, `cmd_out` stays 0 for exactly `cfg_latency` clocks and then the trigger pattern begins. A latency of 0 makes the two patterns contiguous.
- R6: Between the last trigger bit of one pair and the first calibration bit of the next, `cmd_out` stays 0 for exactly `cfg_interval` clocks.
- R7: A run emits exactly `cfg_count` pairs (16-bit count). A `start` with `cfg_count` equal to 0 is ignored: `busy` stays 0 and no `done` is raised.
- R8: `done` is high for exactly one clock, in the clock right after the final trigger bit. `busy` is 0 in that same clock.
- R9: An abort raised during a pattern lets that pattern finish, and the block is idle in the following clock. An abort raised during a latency or interval wait makes the block idle in the next clock. An aborted run raises no `done`.
- R10: A synchronous reset in the middle of a run makes the block idle, with `cmd_out` at 0, in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz command clock |
| rst | input | 1 | Synchronous reset, active high |
| host_bit | input | 1 | Host command bit to relay |
| host_valid | input | 1 | Host bit is offered this clock |
| host_ready | output | 1 | Block accepts the offered host bit |
| start | input | 1 | Begin an automatic calibration/trigger run |
| abort | input | 1 | End the run at the next command edge |
| cfg_latency | input | LAT_W | Zero clocks between calibration end and trigger start |
| cfg_interval | input | GAP_W | Zero clocks between trigger end and next calibration |
| cfg_count | input | CNT_W | Number of calibration/trigger pairs in a run |
| cmd_out | output | 1 | Serial command line to the chip |
| busy | output | 1 | An automatic run is in progress |
| done | output | 1 | One-clock pulse after the final trigger bit |

## Verification
The bench checks the command line bit by bit against a model waveform that it builds from the pattern, latency, interval and count. Any slip in the bit index, the wait counters or the pair count therefore appears on `cmd_out` in the very clock where it occurs. A state machine stuck in a wrong state shows up at once as a wrong `busy` or `host_ready` value, or as a late or missing `done`. The bench samples the ports after each clock edge, so a fault is reported within one clock of the first wrong bit.

// File: rtl/cal_trig_seq.sv
module cal_trig_seq #(
  parameter int CAL_LEN = 9,
  parameter logic [CAL_LEN-1:0] CAL_PAT = 9'b101100100,
  parameter int TRG_LEN = 5,
  parameter logic [TRG_LEN-1:0] TRG_PAT = 5'b11101,
  parameter int LAT_W = 8,
  parameter int GAP_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_bit,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             start,
  input  logic             abort,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic [GAP_W-1:0] cfg_interval,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             cmd_out,
  output logic             busy,
  output logic             done
);
  localparam int PAT_LEN = (CAL_LEN > TRG_LEN) ? CAL_LEN : TRG_LEN;
  localparam int IDX_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam int TMR_W = (LAT_W > GAP_W) ? LAT_W : GAP_W;

  typedef enum logic [2:0] {S_IDLE, S_CAL, S_LAT, S_TRG, S_GAP} state_t;

  state_t             state;
  logic [IDX_W-1:0]   idx;
  logic [TMR_W-1:0]   tmr;
  logic [CNT_W-1:0]   pairs, total;
  logic [LAT_W-1:0]   lat_q;
  logic [GAP_W-1:0]   gap_q;
  logic               stop_q, pass_q, done_q;
  logic [CAL_LEN-1:0] cal_sh;
  logic [TRG_LEN-1:0] trg_sh;
  logic               stop;

  assign busy       = (state != S_IDLE);
  assign host_ready = !busy && !start;
  assign stop       = stop_q || abort;
  assign done       = done_q;
  assign cal_sh     = CAL_PAT << idx;
  assign trg_sh     = TRG_PAT << idx;

  always_comb begin
    case (state)
      S_CAL:   cmd_out = cal_sh[CAL_LEN-1];
      S_TRG:   cmd_out = trg_sh[TRG_LEN-1];
      S_IDLE:  cmd_out = pass_q;
      default: cmd_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      idx    <= '0;
      tmr    <= '0;
      pairs  <= '0;
      total  <= '0;
      lat_q  <= '0;
      gap_q  <= '0;
      stop_q <= 1'b0;
      pass_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pass_q <= host_valid && host_ready && host_bit;
      if (abort && busy) stop_q <= 1'b1;
      case (state)
        S_IDLE: begin
          stop_q <= 1'b0;
          if (start && cfg_count != '0) begin
            state <= S_CAL;
            idx   <= '0;
            pairs <= '0;
            total <= cfg_count;
            lat_q <= cfg_latency;
            gap_q <= cfg_interval;
          end
        end
        S_CAL: begin
          if (idx == IDX_W'(CAL_LEN - 1)) begin
            idx <= '0;
            if (stop) state <= S_IDLE;
            else if (lat_q == '0) state <= S_TRG;
            else begin
              state <= S_LAT;
              tmr   <= TMR_W'(lat_q) - TMR_W'(1);
            end
          end else idx <= idx + IDX_W'(1);
        end
        S_LAT: begin
          if (stop) state <= S_IDLE;
          else if (tmr == '0) begin
            state <= S_TRG;
            idx   <= '0;
          end else tmr <= tmr - TMR_W'(1);
        end
        S_TRG: begin
          if (idx == IDX_W'(TRG_LEN - 1)) begin
            idx   <= '0;
            pairs <= pairs + CNT_W'(1);
            if (pairs + CNT_W'(1) == total) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else if (stop) state <= S_IDLE;
            else if (gap_q == '0) state <= S_CAL;
            else begin
              state <= S_GAP;
              tmr   <= TMR_W'(gap_q) - TMR_W'(1);
            end
          end else idx <= idx + IDX_W'(1);
        end
        S_GAP: begin
          if (stop) state <= S_IDLE;
          else if (tmr == '0) begin
            state <= S_CAL;
            idx   <= '0;
          end else tmr <= tmr - TMR_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_quiet_after_run_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !cmd_out);

  assert_start_emits_cal_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && cfg_count != '0) |=> (state == S_CAL && cmd_out == CAL_PAT[CAL_LEN-1]));

  assert_trg_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_TRG && $past(state) != S_TRG) |-> ($past(state) == S_LAT || $past(state) == S_CAL));

  assert_pair_bound_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pairs < total));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(state) == S_TRG) ##1 !done);

  assert_abort_wait_R9: assert property (@(posedge clk) disable iff (rst)
    ((state == S_LAT || state == S_GAP) && abort) |=> (state == S_IDLE && !done));
endmodule

// File: tb/cal_trig_seq_tb.sv
module cal_trig_seq_tb;
  localparam int CAL_LEN = 9;
  localparam logic [CAL_LEN-1:0] CAL_PAT = 9'b101100100;
  localparam int TRG_LEN = 5;
  localparam logic [TRG_LEN-1:0] TRG_PAT = 5'b11101;

  logic clk = 1'b0;
  logic rst, host_bit, host_valid, start, abort;
  logic [7:0] cfg_latency, cfg_interval;
  logic [15:0] cfg_count;
  logic host_ready, cmd_out, busy, done;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cal_trig_seq u_dut (
    .clk(clk), .rst(rst), .host_bit(host_bit), .host_valid(host_valid),
    .host_ready(host_ready), .start(start), .abort(abort),
    .cfg_latency(cfg_latency), .cfg_interval(cfg_interval), .cfg_count(cfg_count),
    .cmd_out(cmd_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_bit(int pos, int lat, int gap);
    int per = CAL_LEN + lat + TRG_LEN + gap;
    int p = pos % per;
    if (p < CAL_LEN) return int'(CAL_PAT[CAL_LEN-1-p]);
    p -= CAL_LEN;
    if (p < lat) return 0;
    p -= lat;
    if (p < TRG_LEN) return int'(TRG_PAT[TRG_LEN-1-p]);
    return 0;
  endfunction

  task automatic begin_run(int cnt, int lat, int gap);
    cfg_count = 16'(cnt); cfg_latency = 8'(lat); cfg_interval = 8'(gap);
    start = 1'b1; host_valid = 1'b1; host_bit = 1'b1;
    #1 chk(host_ready == 1'b0, "R3 ready with start", int'(host_ready), 0);
    @(negedge clk);
    start = 1'b0; host_valid = 1'b0;
  endtask

  task automatic full_run(int cnt, int lat, int gap, bit noise);
    int len = cnt * (CAL_LEN + lat + TRG_LEN) + (cnt - 1) * gap;
    begin_run(cnt, lat, gap);
    for (int pos = 0; pos < len; pos++) begin
      chk(int'(cmd_out) == exp_bit(pos, lat, gap), "R4/R5/R6 cmd_out bit", int'(cmd_out), exp_bit(pos, lat, gap));
      chk(busy && !done && !host_ready, "R3/R8 busy flags", {busy, done, host_ready}, 3'b100);
      cfg_latency = 8'($urandom); cfg_interval = 8'($urandom); cfg_count = 16'($urandom);
      if (noise) begin
        host_valid = 1'($urandom); host_bit = 1'($urandom);
        start = (pos == 3);
      end
      @(negedge clk);
    end
    host_valid = 1'b0; start = 1'b0;
    chk(done && !busy && !cmd_out, "R7/R8 end of run", {done, busy, cmd_out}, 3'b100);
    @(negedge clk);
    chk(!done && !busy && !cmd_out, "R8 done single", {done, busy, cmd_out}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len;
    void'($urandom(32'd7741));
    rst = 1'b1; host_bit = 0; host_valid = 0; start = 0; abort = 0;
    cfg_latency = 0; cfg_interval = 0; cfg_count = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(!cmd_out && !busy && !done && host_ready, "R1 reset state",
        {cmd_out, busy, done, host_ready}, 4'b0001);

    // R2 pass-through
    for (int i = 0; i < 40; i++) begin
      logic v = 1'($urandom), b = 1'($urandom);
      host_valid = v; host_bit = b;
      #1 chk(host_ready, "R2 ready idle", int'(host_ready), 1);
      @(negedge clk);
      chk(cmd_out == (v & b), "R2 relay bit", int'(cmd_out), int'(v & b));
    end
    host_valid = 0;
    @(negedge clk);

    // R7 zero count ignored
    cfg_count = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !cmd_out, "R7 zero count", {busy, cmd_out}, 0);
    @(negedge clk);
    chk(!busy && !done, "R7 zero count no done", {busy, done}, 0);

    full_run(2, 0, 0, 1'b0);
    full_run(1, 3, 0, 1'b1);
    for (int k = 0; k < 6; k++)
      full_run(1 + int'($urandom % 4), int'($urandom % 13), int'($urandom % 11), 1'b1);

    // R9 abort during calibration pattern
    begin_run(3, 6, 4);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    for (int pos = 1; pos < CAL_LEN; pos++) begin
      chk(int'(cmd_out) == exp_bit(pos, 6, 4), "R9 cal finishes", int'(cmd_out), exp_bit(pos, 6, 4));
      @(negedge clk);
    end
    chk(!busy && !cmd_out && !done, "R9 idle after cal", {busy, cmd_out, done}, 0);
    @(negedge clk);
    chk(!done, "R9 no done", int'(done), 0);

    // R9 abort during latency wait
    begin_run(3, 6, 4);
    repeat (CAL_LEN + 1) @(negedge clk);
    chk(busy && !cmd_out, "R9 in latency", {busy, cmd_out}, 2'b10);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!busy && !cmd_out && !done, "R9 idle after wait", {busy, cmd_out, done}, 0);

    // R10 reset inside trigger pattern
    begin_run(2, 2, 1);
    repeat (CAL_LEN + 2 + 1) @(negedge clk);
    chk(busy && int'(cmd_out) == exp_bit(CAL_LEN + 3, 2, 1), "R10 in trigger", int'(cmd_out), exp_bit(CAL_LEN + 3, 2, 1));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !cmd_out && !done && host_ready, "R10 reset mid-run",
        {busy, cmd_out, done, host_ready}, 4'b0001);
    len = 0;
    full_run(1, 1, 1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule